// File: doc/BRIEF.md
# Dual-Side Integrator Conversion Sequencer

This block sequences a front end built around two integrators, side A and side B, that take turns. An integration on a side ends when the next conversion step is requested. Each end starts a measure/reset/auto-zero (m/r/az) phase on that side. The sequencer reads a conversion-control level, `conv_i`. Every change of that level, rising or falling, requests one step. From the requests it drives which side integrates, whether any side integrates at all, a busy flag for m/r/az activity, and an active-low data-ready strobe.

In non-continuous operation the integrations come in pairs: one side, then the other. An idle stretch follows in which neither side integrates while the two m/r/az phases run. A new pair may start only after both sides are clear and a further preparation interval has passed. A request that arrives too early waits and takes effect in the first cycle it is allowed. In continuous operation the idle stretch is skipped and the sides simply alternate. Each integration start is still gated by that side's own m/r/az phase. Every delay is a parameter in clock cycles. The defaults match a 4 MHz reference clock: 2901 cycles for m/r/az, 72 for preparation, 1379 to the first data-ready and 1450 more to the second. A faster clock is supported by scaling these counts.

Top module: `dsi_seq`

## Requirements
- R1: After reset no side integrates (`int_en_o`=0), `side_o`=0 (side A), `mbsy_o`=0 and `dvalid_no`=1. Both sides count as auto-zeroed, so the first request starts an integration on side A in the same clock edge that samples it.
- R2: Each change of `conv_i` (compared with its value at the previous edge) requests one step. From idle the step starts the first integration of a pair. During the first integration it starts the second integration on the opposite side. During the second integration with `cont_i`=0 it returns to idle.
- R3: From idle, a pair may start only at an edge at least MRAZ_CYC+PREP_CYC+1 cycles after the later of the two most recent integration ends. An earlier request is held and carried out at the first edge that meets this bound.
- R4: An integration end on a side starts MRAZ_CYC cycles of m/r/az on that side. `mbsy_o` is 1 exactly while either side's m/r/az is running.
- R5: An integration may start on a side only at an edge at least MRAZ_CYC+1 cycles after that side's last integration end. An earlier request is held until then.
- R6: A pulse is one cycle of `dvalid_no`=0. A pulse follows DV1_CYC cycles after the edge that ends the first integration of a pair, and another follows DV2_CYC cycles after that. Both pulses fall while m/r/az is running (the parameters keep DV1_CYC+DV2_CYC < MRAZ_CYC).
- R7: In non-continuous operation a new pair starts on the side that integrated last, so an A/B pair is followed by a B/A pair.
- R8: With `cont_i`=1, a request during the second integration goes straight to a new first integration on the opposite side. There is no idle cycle and no preparation wait, and the R5 gate still applies.
- R9: All `conv_i` changes that arrive while a request is held merge into that single request, giving one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_i | input | 1 | Conversion-control level; each change is a step request |
| cont_i | input | 1 | 1 selects continuous alternation, 0 selects paired integrations |
| side_o | output | 1 | Side integrating or last integrated: 0 = A, 1 = B |
| int_en_o | output | 1 | 1 while a side integrates |
| mbsy_o | output | 1 | 1 while any m/r/az phase runs |
| dvalid_no | output | 1 | Data-ready strobe, one-cycle active-low pulse |

## Verification
The assertions check four things on every cycle:
- A pair never starts while m/r/az is busy.
- Every integration end makes the busy flag high.
- The two integrations of a pair use different sides.
- A data-ready pulse appears only while m/r/az runs, and no side ends while its own timer is running.

Only the bench scenarios can show the exact release cycle of a held request and the side chosen for each new pair. The same holds for the merging of several level changes into one step. They also show the exact spacing of the two data-ready pulses and the move from continuous to paired operation and back. The bench compares these against an event-time model over random request spacing.

// File: rtl/dsi_seq_pkg.sv
package dsi_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_INT1 = 2'd1,
    SQ_INT2 = 2'd2
  } sq_state_e;
endpackage

// File: rtl/dsi_mraz_timer.sv
module dsi_mraz_timer #(
  parameter int unsigned MRAZ_CYC = 2901
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(MRAZ_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= CW'(MRAZ_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // a side never ends an integration while its own m/r/az runs
  p_no_reload_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (cnt_q == '0));
endmodule

// File: rtl/dsi_prep_timer.sv
module dsi_prep_timer #(
  parameter int unsigned PREP_CYC = 72
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(PREP_CYC + 2);

  logic [CW-1:0] cnt_q;

  // reloaded while any m/r/az runs, counts out after the last one ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (busy_i)        cnt_q <= CW'(PREP_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = !busy_i && (cnt_q == '0);
endmodule

// File: rtl/dsi_dv_gen.sv
module dsi_dv_gen #(
  parameter int unsigned DV1_CYC = 1379,
  parameter int unsigned DV2_CYC = 1450
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic dvalid_no
);
  localparam int unsigned DMAX = (DV1_CYC > DV2_CYC) ? DV1_CYC : DV2_CYC;
  localparam int unsigned CW   = $clog2(DMAX + 1);

  typedef enum logic [1:0] {DV_OFF, DV_FIRST, DV_SECOND} dv_ph_e;

  dv_ph_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          hit;

  assign hit = (ph_q != DV_OFF) && (cnt_q == CW'(1)) && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= DV_OFF;
      cnt_q     <= '0;
      dvalid_no <= 1'b1;
    end else begin
      dvalid_no <= !hit;
      if (start_i) begin
        ph_q  <= DV_FIRST;
        cnt_q <= CW'(DV1_CYC);
      end else if (ph_q != DV_OFF) begin
        if (cnt_q == CW'(1)) begin
          if (ph_q == DV_FIRST) begin
            ph_q  <= DV_SECOND;
            cnt_q <= CW'(DV2_CYC);
          end else begin
            ph_q  <= DV_OFF;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dsi_seq.sv
module dsi_seq
  import dsi_seq_pkg::*;
#(
  parameter int unsigned MRAZ_CYC = 2901,
  parameter int unsigned PREP_CYC = 72,
  parameter int unsigned DV1_CYC  = 1379,
  parameter int unsigned DV2_CYC  = 1450
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_i,
  input  logic cont_i,
  output logic side_o,
  output logic int_en_o,
  output logic mbsy_o,
  output logic dvalid_no
);
  localparam int unsigned NSIDE = 2;

  sq_state_e        st_q, st_d;
  logic             side_q, side_d;
  logic             conv_q, pend_q;
  logic             req, ok, fire, nside;
  logic [NSIDE-1:0] busy, end_v;
  logic             prep_ok, dv_start;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    assign end_v[s] = fire && (st_q != SQ_IDLE) && (side_q == 1'(s));
    dsi_mraz_timer #(.MRAZ_CYC(MRAZ_CYC)) i_mraz (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (end_v[s]),
      .busy_o (busy[s])
    );
  end

  dsi_prep_timer #(.PREP_CYC(PREP_CYC)) i_prep (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (|busy),
    .ready_o (prep_ok)
  );

  assign dv_start = fire && (st_q == SQ_INT1);

  dsi_dv_gen #(.DV1_CYC(DV1_CYC), .DV2_CYC(DV2_CYC)) i_dv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (dv_start),
    .dvalid_no (dvalid_no)
  );

  assign req   = (conv_i != conv_q) || pend_q;
  // a pair restarts on the side that integrated last
  assign nside = (st_q == SQ_IDLE) ? side_q : !side_q;

  always_comb begin
    ok     = 1'b0;
    st_d   = st_q;
    side_d = side_q;
    unique case (st_q)
      SQ_IDLE: begin
        ok   = prep_ok;
        st_d = SQ_INT1;
        side_d = nside;
      end
      SQ_INT1: begin
        ok   = !busy[nside];
        st_d = SQ_INT2;
        side_d = nside;
      end
      SQ_INT2: begin
        if (cont_i) begin
          ok   = !busy[nside];
          st_d = SQ_INT1;
          side_d = nside;
        end else begin
          ok   = 1'b1;
          st_d = SQ_IDLE;
        end
      end
      default: begin
        ok   = 1'b1;
        st_d = SQ_IDLE;
      end
    endcase
  end

  assign fire = req && ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      side_q <= 1'b0;
      conv_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      conv_q <= conv_i;
      pend_q <= req && !fire;
      if (fire) begin
        st_q   <= st_d;
        side_q <= side_d;
      end
    end
  end

  assign side_o   = side_q;
  assign int_en_o = (st_q != SQ_IDLE);
  assign mbsy_o   = |busy;

  p_pair_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_en_o) |-> !$past(mbsy_o));

  p_end_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_en_o) |-> mbsy_o);

  p_pair_sides_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_INT2 && $past(st_q) == SQ_INT1) |-> (side_q != $past(side_q)));

  p_dv_in_mraz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dvalid_no |-> mbsy_o);
endmodule

// File: tb/test_dsi_seq.sv
`timescale 1ns/1ps
module test_dsi_seq;
  localparam int MRAZ = 60;
  localparam int PREP = 8;
  localparam int DV1  = 20;
  localparam int DV2  = 25;
  localparam int FAR  = -100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv = 1'b0;
  logic cont = 1'b0;
  logic side, int_en, mbsy, dvalid_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit live   = 0;

  always #2 clk = ~clk;

  dsi_seq #(.MRAZ_CYC(MRAZ), .PREP_CYC(PREP), .DV1_CYC(DV1), .DV2_CYC(DV2)) i_dsi_seq (
    .clk_i(clk), .rst_ni(rst_n), .conv_i(conv), .cont_i(cont),
    .side_o(side), .int_en_o(int_en), .mbsy_o(mbsy), .dvalid_no(dvalid_n)
  );

  // event-time reference model, updated at each edge
  int cyc, m_st, m_side, m_e1, m_pend, m_convq, m_dvlow, m_mbsy;
  int m_end [2];

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; m_st = 0; m_side = 0; m_e1 = FAR; m_pend = 0; m_convq = 0;
      m_dvlow = 0; m_mbsy = 0; m_end[0] = FAR; m_end[1] = FAR;
    end else begin
      int p, ns;
      bit rq, ok;
      p = cyc + 1;
      cyc = p;
      rq = (int'(conv) != m_convq) || (m_pend != 0);
      m_convq = int'(conv);
      ok = 0;
      case (m_st)
        0: begin
          ok = p >= imax(m_end[0], m_end[1]) + MRAZ + PREP + 1;
          if (rq && ok) m_st = 1;
        end
        1: begin
          ns = 1 - m_side;
          ok = p >= m_end[ns] + MRAZ + 1;
          if (rq && ok) begin
            m_end[m_side] = p; m_e1 = p; m_st = 2; m_side = ns;
          end
        end
        default: begin
          if (cont) begin
            ns = 1 - m_side;
            ok = p >= m_end[ns] + MRAZ + 1;
            if (rq && ok) begin
              m_end[m_side] = p; m_st = 1; m_side = ns;
            end
          end else begin
            ok = 1;
            if (rq) begin
              m_end[m_side] = p; m_st = 0;
            end
          end
        end
      endcase
      m_pend  = (rq && !ok) ? 1 : 0;
      m_dvlow = (p == m_e1 + DV1 || p == m_e1 + DV1 + DV2) ? 1 : 0;
      m_mbsy  = (p < m_end[0] + MRAZ || p < m_end[1] + MRAZ) ? 1 : 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cyc %0d: got %0d exp %0d", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      check("R2", "int_en", int'(int_en), (m_st != 0) ? 1 : 0);
      check("R2", "side", int'(side), m_side);
      check("R4", "mbsy", int'(mbsy), m_mbsy);
      check("R6", "dvalid_n", int'(dvalid_n), 1 - m_dvlow);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle();
    conv = ~conv;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired at cyc %0d", cyc);
    finish_run();
  end

  initial begin
    int t_end;
    void'($urandom(32'd20240611));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1", "reset int_en", int'(int_en), 0);
    check("R1", "reset side", int'(side), 0);
    check("R1", "reset mbsy", int'(mbsy), 0);
    check("R1", "reset dvalid_n", int'(dvalid_n), 1);
    live = 1;
    tick(2);
    toggle(); tick(1);
    check("R1", "first start immediate", int'(int_en), 1);
    check("R1", "first side A", int'(side), 0);
    tick(4); toggle(); tick(1);
    check("R2", "second of pair on B", int'(side), 1);
    tick(4); toggle(); t_end = cyc + 1; tick(1);
    check("R2", "idle after pair", int'(int_en), 0);
    // early request, then a second change while held (R9)
    toggle(); tick(1); toggle();
    while (cyc < t_end + MRAZ + PREP) tick(1);
    check("R3", "held before bound", int'(int_en), 0);
    tick(1);
    check("R3", "start at bound", int'(int_en), 1);
    check("R7", "pair restarts on B", int'(side), 1);
    tick(2);
    check("R9", "merged changes one step", int'(side), 1);
    // continuous: straight back to a new first integration, gated by R5
    cont = 1'b1;
    toggle(); t_end = cyc + 1; tick(1);
    check("R2", "second of B/A pair on A", int'(side), 0);
    toggle();
    while (cyc < t_end + MRAZ) begin
      tick(1);
      if (cyc < t_end + MRAZ) begin
        check("R8", "no idle in cont", int'(int_en), 1);
        check("R5", "B start held", int'(side), 0);
      end
    end
    tick(1);
    check("R5", "B start after its m/r/az", int'(side), 1);
    check("R8", "cont still integrating", int'(int_en), 1);
    // random phase
    for (int i = 0; i < 400; i++) begin
      tick($urandom_range(1, 2 * MRAZ));
      toggle();
      if ($urandom_range(0, 7) == 0) begin
        tick(1); toggle();
      end
      if ($urandom_range(0, 9) == 0) cont = ~cont;
    end
    tick(3 * MRAZ);
    finish_run();
  end
endmodule